// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is one transmit channel of a microcontroller serial unit. Words arrive on a valid/ready input, wait in a one-entry holding buffer and move into a shift stage that sends one asynchronous frame per word on a single output line. The frame shape is chosen at run time through one configuration word. That word sets the data width (5, 7 or 8 bits), the parity kind, the number of stop bits, the bit order, the line polarity, the bit-rate divider, a power-of-two prescaler and the meaning of the interrupt.

In single-transfer use, the interrupt reports that a frame has been fully sent. In continuous use, it reports that the holding buffer has been emptied, so software can queue the next word while the current one shifts. Frames then follow each other with no idle gap.

Back-pressure rules: `s_ready` is high exactly when the holding buffer is empty. A word is taken on any rising edge where `s_valid` and `s_ready` are both high. A source must not hold `s_valid` high while `s_ready` is low. Such a cycle counts as a write into a full buffer: the word is lost and the sticky overrun flag is set.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset, `tx` is high, `s_ready` is high, and `irq` and `ovr` are low.
- R2: Each frame is sent in this order: one start bit at logic 0, then the data bits, then the parity bit if enabled, then the stop bits at logic 1. The configuration field `len` (bits 1:0) selects the data width: 0 gives 5 bits, 1 gives 7 bits, 2 or 3 gives 8 bits. Data bits above the selected width are ignored.
- R3: When bit 5 (`msb_first`) is 0, the data bits go out from bit 0 upward. When it is 1, they go out from the top bit of the selected width downward.
- R4: Field `par` (bits 3:2) selects the parity: 0 sends no parity bit, 1 sends a parity bit of constant 0, 2 sends even parity, 3 sends odd parity. Even and odd parity are computed only over the selected data bits.
- R5: Bit 4 (`stop2`) selects two stop bits when 1 and one stop bit when 0. After the last stop bit the line returns to idle.
- R6: When bit 6 (`invert`) is 1, the whole output waveform, including the idle level, is inverted, so the line idles low.
- R7: Each bit lasts 2 × (div + 1) × 2^k clock cycles. Here div is bits 14:8 and k is bits 18:15; k values above 11 act as 11.
- R8: With bit 7 (`irq_cont`) at 0, `irq` is a one-cycle pulse in the cycle right after the final stop bit period ends.
- R9: With `irq_cont` at 1, `irq` is a one-cycle pulse in the first cycle of each frame, which is when the holding buffer is emptied. A word waiting in the buffer starts its frame in the cycle right after the previous frame ends.
- R10: `s_ready` is high exactly when the holding buffer is empty. It goes low in the cycle after a word is accepted, and it rises again in the cycle in which that word's start bit is driven.
- R11: A cycle with `s_valid` high and `s_ready` low drops the word and sets `ovr`. `ovr` stays set until a cycle with `ovr_clr` high and no new overrun.
- R12: A configuration write is ignored while a frame is being sent or a word is waiting in the buffer. It is also ignored if its div field is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 19 | Configuration word (fields as in R2 to R9, R12) |
| s_valid | input | 1 | Data word valid |
| s_ready | output | 1 | Holding buffer empty |
| s_data | input | 8 | Data word |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx | output | 1 | Serial output line |
| irq | output | 1 | Interrupt pulse |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Let E0 be the rising edge at which a word is accepted. `s_ready` falls in the cycle after E0. If the shift stage is idle, the start bit appears in the cycle after the next edge E1 = E0 + 1. Bit i then occupies cycles E1 + i·P through E1 + (i+1)·P − 1, where P is the bit period. The continuous-mode interrupt is due in cycle E1. The single-mode interrupt is due in cycle E1 + n·P for an n-bit frame. `ovr` is due one cycle after the rejected cycle. The bench logs `tx` and `irq` at every falling edge, indexed by the edge count. Each data bit is compared at its mid-bit index E1 + i·P + P/2, and each interrupt at its exact index, so every check falls in the cycle where the result is due.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DIV_W   = 7;
  localparam int PRE_W   = 4;
  localparam int MAX_PRE = 11;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int NB_W    = $clog2(FRAME_W + 1);
  localparam int CFG_W   = PRE_W + DIV_W + 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ZERO = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_ODD  = 2'd3
  } par_e;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [DIV_W-1:0] div;
    logic             irq_cont;
    logic             invert;
    logic             msb_first;
    logic             stop2;
    par_e             parity;
    logic [1:0]       len;
  } cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [NB_W-1:0]    n;
  } frame_t;

  function automatic int data_len(input logic [1:0] code);
    case (code)
      2'd0:    return 5;
      2'd1:    return 7;
      default: return DATA_W;
    endcase
  endfunction

  // Frame laid out in send order, bit 0 first; unused positions stay at 1.
  function automatic frame_t build_frame(input cfg_t c, input logic [DATA_W-1:0] d);
    frame_t f;
    int dl;
    int pos;
    logic [DATA_W-1:0] mask;
    logic p;
    dl = data_len(c.len);
    f.bits = '1;
    f.bits[0] = 1'b0;
    pos = 1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dl) begin
        f.bits[pos] = c.msb_first ? d[dl - 1 - i] : d[i];
        pos++;
      end
    end
    mask = {DATA_W{1'b1}} >> (DATA_W - dl);
    p = ^(d & mask);
    case (c.parity)
      PAR_ZERO: begin f.bits[pos] = 1'b0; pos++; end
      PAR_EVEN: begin f.bits[pos] = p;    pos++; end
      PAR_ODD:  begin f.bits[pos] = ~p;   pos++; end
      default:  ;
    endcase
    f.n = NB_W'(pos + 1 + int'(c.stop2));
    return f;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W   = 7,
  parameter int PRE_W   = 4,
  parameter int MAX_PRE = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  localparam int CNT_W = DIV_W + MAX_PRE + 2;

  logic [PRE_W-1:0] k_eff;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    k_eff     = (presc > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : presc;
    period_m1 = ((CNT_W'(div) + CNT_W'(1)) << (CNT_W'(k_eff) + CNT_W'(1))) - CNT_W'(1);
    tick      = run && (cnt == period_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  // R7: the counter never passes the end of the bit period
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= period_m1);
  // R7: counting restarts after each bit boundary
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == '0);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int NB_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NB_W-1:0]    nbits,
  input  logic               tick,
  output logic               line,
  output logic               busy,
  output logic               last
);
  logic [FRAME_W-1:0] sh;
  logic [NB_W-1:0]    rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      rem  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame;
      rem  <= nbits;
      busy <= 1'b1;
    end else if (busy && tick) begin
      sh  <= {1'b1, sh[FRAME_W-1:1]};
      rem <= rem - NB_W'(1);
      if (rem == NB_W'(1)) busy <= 1'b0;
    end
  end

  always_comb begin
    line = busy ? sh[0] : 1'b1;
    last = busy && tick && (rem == NB_W'(1));
  end

  // R2: a new frame always opens with the start level
  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
  // R5: an active frame always has bits left to send
  a_r5_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem != '0);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              ovr_clr,
  output logic              tx,
  output logic              irq,
  output logic              ovr
);
  localparam cfg_t CFG_RST = '{presc: '0, div: DIV_W'(2), irq_cont: 1'b0,
                               invert: 1'b0, msb_first: 1'b0, stop2: 1'b0,
                               parity: PAR_NONE, len: 2'd2};

  cfg_t              cfg_q;
  cfg_t              cfg_in;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic              sh_busy, sh_last, sh_line, tick;
  logic              load, accept, cfg_lock;
  frame_t            fr;

  always_comb begin
    cfg_in   = cfg_t'(cfg_wdata);
    cfg_lock = sh_busy || hold_full;
    s_ready  = !hold_full;
    accept   = s_valid && s_ready;
    load     = hold_full && (!sh_busy || sh_last);
    fr       = build_frame(cfg_q, hold_q);
    tx       = sh_line ^ cfg_q.invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cfg_we && !cfg_lock && (cfg_in.div >= DIV_W'(2))) cfg_q <= cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_q    <= s_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      ovr <= 1'b0;
    end else begin
      irq <= cfg_q.irq_cont ? load : sh_last;
      if (s_valid && !s_ready) ovr <= 1'b1;
      else if (ovr_clr)        ovr <= 1'b0;
    end
  end

  uart_baud_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(sh_busy),
    .div(cfg_q.div), .presc(cfg_q.presc), .tick(tick)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .NB_W(NB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .frame(fr.bits), .nbits(fr.n),
    .tick(tick), .line(sh_line), .busy(sh_busy), .last(sh_last)
  );

  // R10: an accepted word closes the buffer on the next cycle
  a_r10_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_ready);
  // R11: overrun is sticky until cleared
  a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !ovr_clr |=> ovr);
  // R12: configuration cannot move while a transfer is pending
  a_r12_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(cfg_q));
  // R8 R9: the interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: idle line sits at the configured rest level
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> tx == !cfg_q.invert);
endmodule

// File: tb/uart_tx_chan_test.sv
module uart_tx_chan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = '0;
  logic ovr_clr = 1'b0;
  logic tx, irq, ovr;

  always #2 clk = ~clk;

  uart_tx_chan uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .ovr_clr(ovr_clr),
    .tx(tx), .irq(irq), .ovr(ovr)
  );

  int pcyc = 0;
  logic txlog [0:8191];
  logic irqlog [0:8191];
  always @(posedge clk) pcyc++;
  always @(negedge clk) if (pcyc < 8192) begin txlog[pcyc] = tx; irqlog[pcyc] = irq; end

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_cfg(input int len, input int par, input int st2,
      input int msb, input int inv, input int cont, input int div, input int k);
    return 19'((k << 15) | (div << 8) | (cont << 7) | (inv << 6) | (msb << 5) |
               (st2 << 4) | (par << 2) | len);
  endfunction

  function automatic void exp_frame(input int len, input int par, input int st2,
      input int msb, input logic [7:0] d, output logic [15:0] b, output int n);
    int dl;
    int k;
    logic pb;
    dl = (len == 0) ? 5 : (len == 1) ? 7 : 8;
    pb = 1'b0;
    b = '1;
    b[0] = 1'b0;
    n = 1;
    for (int i = 0; i < dl; i++) begin
      k = (msb != 0) ? dl - 1 - i : i;
      b[n] = d[k];
      pb ^= d[k];
      n++;
    end
    if (par == 1) begin b[n] = 1'b0; n++; end
    else if (par == 2) begin b[n] = pb; n++; end
    else if (par == 3) begin b[n] = ~pb; n++; end
    n += 1 + st2;
  endfunction

  task automatic wr_cfg(input logic [18:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, output int e1);
    @(negedge clk); s_valid = 1'b1; s_data = d;
    @(negedge clk); e1 = pcyc + 1; s_valid = 1'b0;
  endtask

  task automatic wait_idx(input int idx);
    while (pcyc <= idx) @(negedge clk);
  endtask

  task automatic check_frame(input int e1, input int p, input logic [15:0] b,
      input int n, input int inv, input string tag);
    wait_idx(e1 + n * p + p / 2);
    for (int i = 0; i < n; i++)
      chk(txlog[e1 + i * p + p / 2] == (b[i] ^ inv[0]), tag,
          int'(txlog[e1 + i * p + p / 2]), int'(b[i] ^ inv[0]));
  endtask

  // {len[1:0], par[1:0], stop2, msb, inv, data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'h55},
    {2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 8'hC3},
    {2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 8'h1D},
    {2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 8'hA6},
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 8'h80},
    {2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 8'h01},
    {2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 8'h7E}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pcyc, 0);
    finish_run();
  end

  initial begin
    int e1, e1b, n, ln, pr, st, ms, iv;
    logic [15:0] b;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    chk(s_ready == 1'b1, "R1 ready", int'(s_ready), 1);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(ovr == 1'b0, "R1 ovr", int'(ovr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of frame formats, bit period 6
    foreach (VEC[v]) begin
      ln = int'(VEC[v][14:13]); pr = int'(VEC[v][12:11]);
      st = int'(VEC[v][10]); ms = int'(VEC[v][9]); iv = int'(VEC[v][8]);
      d = VEC[v][7:0];
      wr_cfg(mk_cfg(ln, pr, st, ms, iv, 0, 2, 0));
      @(negedge clk);
      chk(tx == ~iv[0], "R6 idle level", int'(tx), int'(~iv[0]));
      send(d, e1);
      exp_frame(ln, pr, st, ms, d, b, n);
      check_frame(e1, 6, b, n, iv, "R2 R3 R4 R5 frame bit");
      chk(txlog[e1 + n * 6 + 3] == ~iv[0], "R5 R6 idle after", int'(txlog[e1 + n * 6 + 3]), int'(~iv[0]));
      chk(irqlog[e1 + n * 6] == 1'b1, "R8 irq at end", int'(irqlog[e1 + n * 6]), 1);
      chk(irqlog[e1 + n * 6 - 1] == 1'b0, "R8 irq not early", int'(irqlog[e1 + n * 6 - 1]), 0);
    end

    // R12: write during a frame is ignored
    wr_cfg(mk_cfg(2, 0, 0, 0, 0, 0, 2, 0));
    send(8'h3C, e1);
    wait_idx(e1 + 10);
    wr_cfg(mk_cfg(0, 2, 1, 1, 1, 0, 2, 0));
    wait_idx(e1 + 62);
    send(8'h3C, e1);
    exp_frame(2, 0, 0, 0, 8'h3C, b, n);
    check_frame(e1, 6, b, n, 0, "R12 busy write ignored");
    // R12: divider below 2 is rejected
    wr_cfg(mk_cfg(0, 1, 1, 1, 1, 0, 1, 0));
    send(8'hC5, e1);
    check_frame(e1, 6, b ^ b ^ 16'hFFFF, 0, 0, "R12 unused");
    exp_frame(2, 0, 0, 0, 8'hC5, b, n);
    check_frame(e1, 6, b, n, 0, "R12 low divider ignored");

    // R7: k=1, div=3 gives 16 cycles per bit
    wr_cfg(mk_cfg(2, 0, 0, 0, 0, 0, 3, 1));
    send(8'hFF, e1);
    wait_idx(e1 + 17);
    chk(txlog[e1 - 1] == 1'b1, "R7 before start", int'(txlog[e1 - 1]), 1);
    chk(txlog[e1] == 1'b0, "R7 start begins", int'(txlog[e1]), 0);
    chk(txlog[e1 + 15] == 1'b0, "R7 start lasts", int'(txlog[e1 + 15]), 0);
    chk(txlog[e1 + 16] == 1'b1, "R7 start ends", int'(txlog[e1 + 16]), 1);
    exp_frame(2, 0, 0, 0, 8'hFF, b, n);
    check_frame(e1, 16, b, n, 0, "R7 slow frame");
    wait_idx(e1 + n * 16 + 2);

    // R9 R10 R11: continuous mode, back-to-back, overrun
    wr_cfg(mk_cfg(2, 0, 0, 0, 0, 1, 2, 0));
    send(8'h96, e1);
    wait_idx(e1);
    chk(irqlog[e1] == 1'b1, "R9 irq on buffer empty", int'(irqlog[e1]), 1);
    chk(s_ready == 1'b1, "R10 ready after transfer", int'(s_ready), 1);
    send(8'h3B, e1b);
    chk(s_ready == 1'b0, "R10 ready low when full", int'(s_ready), 0);
    @(negedge clk); s_valid = 1'b1; s_data = 8'hE7;
    @(negedge clk); s_valid = 1'b0;
    chk(ovr == 1'b1, "R11 overrun set", int'(ovr), 1);
    exp_frame(2, 0, 0, 0, 8'h96, b, n);
    check_frame(e1, 6, b, n, 0, "R9 first frame");
    chk(irqlog[e1 + 60] == 1'b1, "R9 irq second frame", int'(irqlog[e1 + 60]), 1);
    chk(irqlog[e1 + 59] == 1'b0, "R9 no end irq", int'(irqlog[e1 + 59]), 0);
    exp_frame(2, 0, 0, 0, 8'h3B, b, n);
    check_frame(e1 + 60, 6, b, n, 0, "R9 R11 second frame");
    wait_idx(e1 + 125);
    chk(txlog[e1 + 123] == 1'b1, "R11 dropped word not sent", int'(txlog[e1 + 123]), 1);
    chk(ovr == 1'b1, "R11 overrun sticky", int'(ovr), 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(ovr == 1'b0, "R11 overrun cleared", int'(ovr), 0);

    finish_run();
  end
endmodule